// File: doc/BRIEF.md
# Isochronous Packet Framer

This block turns one streaming transfer request into a framed isochronous packet, one 32-bit quadlet per output beat. A request gives a channel number, a speed code, a tag value, a sync value and a payload length in bytes. Once the request is taken, the payload arrives as quadlets on a valid/ready input. The block sends them out on a valid/ready output marked with a last flag. The packet goes out in a fixed order: the header quadlet, a checksum over that header, the payload quadlets unchanged, and a checksum over the payload only.

Isochronous traffic is never acknowledged. The framer therefore goes back to accepting requests as soon as the final checksum quadlet has been taken. Before any output is produced, each request is checked against the payload limit of its speed code. A request that breaks that limit, or that is not a whole number of quadlets, is refused with a single-cycle error pulse and leaves no trace on the output.

Top module: `iso_framer`

## Requirements
- R1: The header quadlet is laid out as data length in bytes [31:16], tag [15:14], channel [13:8], transaction code [7:4], sync [3:0], and the transaction code field always holds 4'hA.
- R2: An accepted request with N payload quadlets produces exactly N+3 output beats: header, header checksum, the N payload quadlets, then the data checksum. `out_last` is high on the data checksum beat and on no other beat.
- R3: The header checksum is the bitwise complement of a CRC-32 computed with polynomial 0x04C11DB7. The CRC starts from 32'hFFFFFFFF, takes the header quadlet most significant bit first, and has no bit reflection.
- R4: The data checksum uses the same CRC rule over the payload quadlets only, in arrival order, restarting from all-ones for each packet. A zero-length packet therefore ends with 32'h00000000.
- R5: The payload limit is 1024 bytes for speed code 0, 2048 for code 1 and 4096 for code 2. A length equal to the limit is accepted. Speed code 3 is refused at any length.
- R6: A refused request (over the limit, speed code 3, or length not a multiple of 4) raises `err_len` for exactly the one cycle after the request handshake. It produces no output beat, and `pl_ready` stays low.
- R7: In the cycle after the data checksum beat is accepted, `out_valid` is low and `req_ready` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values, and neither checksum is disturbed by the stall.
- R9: `pl_ready` is high only during the payload phase, where it follows `out_ready`. Each payload quadlet appears on `out_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Packet request present |
| req_ready | output | 1 | Framer is idle and takes a request |
| req_channel | input | 6 | Isochronous channel number |
| req_speed | input | 2 | Speed code: 0, 1, 2 valid; 3 refused |
| req_tag | input | 2 | Tag field value |
| req_sync | input | 4 | Sync field value |
| req_len | input | 16 | Payload length in bytes |
| pl_valid | input | 1 | Payload quadlet present |
| pl_ready | output | 1 | Payload quadlet taken this cycle |
| pl_data | input | 32 | Payload quadlet |
| out_valid | output | 1 | Output quadlet present |
| out_ready | input | 1 | Downstream takes the output quadlet |
| out_data | output | 32 | Output quadlet |
| out_last | output | 1 | Marks the data checksum, the final beat |
| err_len | output | 1 | One-cycle pulse on a refused request |

## Verification
The hold property on the output assumes the payload source never withdraws `pl_valid` or changes `pl_data` once it has offered a quadlet that is not yet taken. During the payload phase the output beat is the payload beat passed straight through. The bench drivers keep to this rule: they only insert idle gaps before raising `pl_valid`, and they keep each quadlet in place until `pl_ready` is seen. The refusal property assumes requests are only offered while the framer is idle. The bench issues a request only after the previous packet has been fully collected.

// File: rtl/iso_pkg.sv
package iso_pkg;
  localparam int Q_W    = 32;
  localparam int LEN_W  = 16;
  localparam int TAG_W  = 2;
  localparam int CH_W   = 6;
  localparam int SYNC_W = 4;
  localparam int SPD_W  = 2;
  localparam int WRD_W  = LEN_W - 2;

  localparam logic [3:0]     TCODE_ISO = 4'hA;
  localparam logic [Q_W-1:0] CRC_POLY  = 32'h04C11DB7;
  localparam logic [Q_W-1:0] CRC_SEED  = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_HCRC,
    ST_DATA,
    ST_DCRC
  } frm_state_e;

  // Advance a CRC-32 register over one quadlet, MSB first.
  function automatic logic [Q_W-1:0] crc_quad(input logic [Q_W-1:0] c_in,
                                               input logic [Q_W-1:0] d);
    logic [Q_W-1:0] c;
    logic           fb;
    c = c_in;
    for (int i = Q_W - 1; i >= 0; i--) begin
      fb = c[Q_W-1] ^ d[i];
      c  = {c[Q_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

  // Byte limit for a speed code; code 3 has none.
  function automatic int unsigned speed_limit(input logic [SPD_W-1:0] spd,
                                              input int unsigned base);
    if (spd == 2'd3) return 0;
    return base << spd;
  endfunction

  function automatic logic [Q_W-1:0] build_header(input logic [LEN_W-1:0]  len,
                                                  input logic [TAG_W-1:0]  tag,
                                                  input logic [CH_W-1:0]   ch,
                                                  input logic [SYNC_W-1:0] sy);
    return {len, tag, ch, TCODE_ISO, sy};
  endfunction
endpackage

// File: rtl/iso_len_check.sv
module iso_len_check
  import iso_pkg::*;
#(
  parameter int unsigned BASE_BYTES = 1024
) (
  input  logic [LEN_W-1:0] len,
  input  logic [SPD_W-1:0] spd,
  output logic             len_ok,
  output logic [WRD_W-1:0] n_words
);
  int unsigned lim_bytes;
  logic        aligned;
  logic        spd_ok;
  logic        in_limit;

  always_comb begin
    lim_bytes = speed_limit(spd, BASE_BYTES);
    aligned   = (len[1:0] == 2'b00);
    spd_ok    = (spd != 2'd3);
    in_limit  = (32'(len) <= lim_bytes);
    len_ok    = aligned && spd_ok && in_limit;
    n_words   = len[LEN_W-1:2];
  end
endmodule

// File: rtl/iso_crc_acc.sv
module iso_crc_acc
  import iso_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [Q_W-1:0] din,
  output logic [Q_W-1:0] crc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= CRC_SEED;
    else if (load) crc_q <= CRC_SEED;
    else if (step) crc_q <= crc_quad(crc_q, din);
  end
endmodule

// File: rtl/iso_framer.sv
module iso_framer
  import iso_pkg::*;
#(
  parameter int unsigned BASE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_channel,
  input  logic [SPD_W-1:0]  req_speed,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [SYNC_W-1:0] req_sync,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [Q_W-1:0]    pl_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [Q_W-1:0]    out_data,
  output logic              out_last,
  output logic              err_len
);
  frm_state_e       state_q, state_d;
  logic [Q_W-1:0]   hdr_q;
  logic [WRD_W-1:0] left_q;
  logic             err_q;
  logic [Q_W-1:0]   dcrc_q;

  logic             len_ok;
  logic [WRD_W-1:0] n_words;

  // Named events for the checker.
  logic st_idle, hdr_phase, hcrc_phase, data_phase, dcrc_phase;
  logic req_fire, req_take, req_refuse, out_fire, data_fire;

  iso_len_check #(.BASE_BYTES(BASE_BYTES)) u_len (
    .len     (req_len),
    .spd     (req_speed),
    .len_ok  (len_ok),
    .n_words (n_words)
  );

  assign st_idle    = (state_q == ST_IDLE);
  assign hdr_phase  = (state_q == ST_HDR);
  assign hcrc_phase = (state_q == ST_HCRC);
  assign data_phase = (state_q == ST_DATA);
  assign dcrc_phase = (state_q == ST_DCRC);

  assign req_ready  = st_idle;
  assign req_fire   = req_valid && req_ready;
  assign req_take   = req_fire && len_ok;
  assign req_refuse = req_fire && !len_ok;

  assign out_valid  = hdr_phase || hcrc_phase || dcrc_phase || (data_phase && pl_valid);
  assign pl_ready   = data_phase && out_ready;
  assign out_fire   = out_valid && out_ready;
  assign data_fire  = data_phase && pl_valid && out_ready;
  assign out_last   = dcrc_phase;
  assign err_len    = err_q;

  iso_crc_acc u_dcrc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (req_take),
    .step  (data_fire),
    .din   (pl_data),
    .crc_q (dcrc_q)
  );

  always_comb begin
    unique case (state_q)
      ST_HDR:  out_data = hdr_q;
      ST_HCRC: out_data = ~crc_quad(CRC_SEED, hdr_q);
      ST_DATA: out_data = pl_data;
      ST_DCRC: out_data = ~dcrc_q;
      default: out_data = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_take) state_d = ST_HDR;
      ST_HDR:  if (out_fire) state_d = ST_HCRC;
      ST_HCRC: if (out_fire) state_d = (left_q == '0) ? ST_DCRC : ST_DATA;
      ST_DATA: if (data_fire && left_q == WRD_W'(1)) state_d = ST_DCRC;
      ST_DCRC: if (out_fire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      left_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= req_refuse;
      if (req_take) begin
        hdr_q  <= build_header(req_len, req_tag, req_channel, req_sync);
        left_q <= n_words;
      end else if (data_fire) begin
        left_q <= left_q - WRD_W'(1);
      end
    end
  end
endmodule

// File: rtl/iso_framer_chk.sv
module iso_framer_chk
  import iso_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [SPD_W-1:0]  req_speed,
  input logic [LEN_W-1:0]  req_len,
  input logic              pl_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [Q_W-1:0]    out_data,
  input logic              out_last,
  input logic              err_len,
  input logic              hdr_phase,
  input logic              data_phase
);
  p_tcode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_phase && out_valid |-> out_data[7:4] == 4'hA);

  p_last_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && req_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_refuse_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_len |-> !out_valid && !pl_ready);

  p_over_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_speed == 2'd0 && req_len > 16'd1024 |=> err_len);

  p_pl_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> data_phase && out_ready);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !out_valid && !out_last);
endmodule

bind iso_framer iso_framer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_speed  (req_speed),
  .req_len    (req_len),
  .pl_ready   (pl_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_last   (out_last),
  .err_len    (err_len),
  .hdr_phase  (hdr_phase),
  .data_phase (data_phase)
);

// File: tb/test_iso_framer.sv
module test_iso_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_channel = '0;
  logic [1:0]  req_speed = '0;
  logic [1:0]  req_tag = '0;
  logic [3:0]  req_sync = '0;
  logic [15:0] req_len = '0;
  logic        pl_valid = 1'b0;
  logic        pl_ready;
  logic [31:0] pl_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_last;
  logic        err_len;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  iso_framer i_iso_framer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_channel(req_channel), .req_speed(req_speed), .req_tag(req_tag),
    .req_sync(req_sync), .req_len(req_len),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .err_len(err_len)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", rq, act, exp, $time);
    end
  endtask

  // Bench CRC: fold the word in, then shift 32 times.
  function automatic logic [31:0] b_crc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c ^ d;
    for (int k = 0; k < 32; k++)
      r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    return r;
  endfunction

  function automatic logic [31:0] word_of(input int seed, input int i);
    return 32'h5A3C0000 ^ (32'(seed) << 24) ^ (32'(i) * 32'h00010003);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic drive(input int nw, input int mode, input int seed);
    bit took;
    for (int i = 0; i < nw; i++) begin
      if (mode != 0 && (i % 4) == 3) begin
        pl_valid = 1'b0;
        @(negedge clk);
      end
      pl_valid = 1'b1;
      pl_data  = word_of(seed, i);
      do begin
        #3;
        took = pl_ready;
        @(negedge clk);
      end while (!took);
    end
    pl_valid = 1'b0;
  endtask

  task automatic collect(input int mode, ref logic [31:0] got[$], input int n_exp);
    bit          done = 0;
    bit          stalled = 0;
    logic [31:0] held = '0;
    logic        held_last = 1'b0;
    int          k = 0;
    while (!done) begin
      @(negedge clk);
      out_ready = (mode == 0) ? 1'b1 : ((k % 3) != 1);
      k++;
      #2;
      if (stalled) begin
        check(out_valid && out_data == held && out_last == held_last,
              "R8 stall hold", out_data, held);
        stalled = 0;
      end
      if (out_valid && out_ready) begin
        got.push_back(out_data);
        check(out_last == (got.size() == n_exp), "R2 last flag position",
              32'(out_last), 32'(got.size() == n_exp));
        if (out_last) done = 1;
      end else if (out_valid) begin
        stalled   = 1;
        held      = out_data;
        held_last = out_last;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    #2;
    check(req_ready && !out_valid, "R7 idle after data checksum",
          {30'd0, req_ready, out_valid}, 32'h2);
  endtask

  task automatic run_pkt(input logic [5:0] ch, input logic [1:0] spd,
                         input logic [1:0] tg, input logic [3:0] sy,
                         input int nw, input int mode, input int seed, input string nm);
    logic [31:0] exp[$];
    logic [31:0] got[$];
    logic [31:0] hdr, c;
    int          bad = 0;
    hdr = {16'(nw * 4), tg, ch, 4'hA, sy};
    exp.push_back(hdr);
    exp.push_back(~b_crc(32'hFFFFFFFF, hdr));
    c = 32'hFFFFFFFF;
    for (int i = 0; i < nw; i++) begin
      exp.push_back(word_of(seed, i));
      c = b_crc(c, word_of(seed, i));
    end
    exp.push_back(~c);

    @(negedge clk);
    req_channel = ch; req_speed = spd; req_tag = tg; req_sync = sy;
    req_len = 16'(nw * 4); req_valid = 1'b1;
    #3;
    check(req_ready, {nm, " R5 request accepted"}, 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    fork
      drive(nw, mode, seed);
      collect(mode, got, exp.size());
    join
    check(got.size() == exp.size(), {nm, " R2 beat count"}, 32'(got.size()), 32'(exp.size()));
    if (got.size() == exp.size()) begin
      check(got[0] == exp[0], {nm, " R1 header quadlet"}, got[0], exp[0]);
      check(got[1] == exp[1], {nm, " R3 header checksum"}, got[1], exp[1]);
      for (int i = 2; i < exp.size() - 1; i++)
        if (got[i] != exp[i]) bad++;
      check(bad == 0, {nm, " R9 payload passthrough"}, 32'(bad), 32'd0);
      check(got[exp.size()-1] == exp[exp.size()-1], {nm, " R4 data checksum"},
            got[exp.size()-1], exp[exp.size()-1]);
    end
  endtask

  task automatic run_refuse(input logic [1:0] spd, input logic [15:0] len, input string nm);
    @(negedge clk);
    req_speed = spd; req_len = len; req_valid = 1'b1; pl_valid = 1'b1;
    pl_data = 32'hDEADBEEF;
    #3;
    check(req_ready && !err_len, {nm, " R6 no early pulse"},
          {30'd0, req_ready, err_len}, 32'h2);
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    check(err_len && !out_valid && !pl_ready, {nm, " R6 pulse and quiet"},
          {29'd0, err_len, out_valid, pl_ready}, 32'h4);
    @(negedge clk);
    #2;
    check(!err_len && !out_valid && req_ready, {nm, " R6 single-cycle pulse"},
          {29'd0, err_len, out_valid, req_ready}, 32'h1);
    pl_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(!out_valid && req_ready && !err_len && !pl_ready, "R7 reset state",
          {28'd0, out_valid, req_ready, err_len, pl_ready}, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    t_reset();
    run_pkt(6'd5,  2'd0, 2'd1, 4'h3, 4,    0, 1, "basic");
    run_pkt(6'd63, 2'd1, 2'd3, 4'hF, 10,   1, 2, "backpressure");
    run_pkt(6'd0,  2'd2, 2'd0, 4'h0, 0,    1, 3, "empty");
    run_pkt(6'd17, 2'd0, 2'd2, 4'h9, 256,  1, 4, "limit100");
    run_pkt(6'd33, 2'd1, 2'd1, 4'h6, 512,  0, 5, "limit200");
    run_pkt(6'd42, 2'd2, 2'd2, 4'hC, 1024, 1, 6, "limit400");
    run_refuse(2'd0, 16'd1028, "R5 over100");
    run_refuse(2'd1, 16'd2052, "R5 over200");
    run_refuse(2'd2, 16'd4100, "R5 over400");
    run_refuse(2'd3, 16'd4,    "R5 speed3");
    run_refuse(2'd0, 16'd6,    "misaligned");
    run_pkt(6'd9,  2'd0, 2'd0, 4'h1, 3,    1, 7, "after refuse");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule